// File: doc/BRIEF.md
# Speculative Instruction Reorder Buffer

This block tracks in-flight instructions of an out-of-order core in a circular buffer of `DEPTH` slots (8 by default, a power of two). Each slot records a small status word, the physical tag it writes, two source tags, the tag it replaces and a branch snapshot identifier. The front end inserts at the tail. Two pickers offer work to the execution side. One offers the oldest ready arithmetic entry, searching from the head and wrapping. The other offers only the oldest unfinished in-order entry, which covers branches, jumps and serializing operations.

Result writebacks finish their entry and broadcast their tag, so that dependent entries become ready. Branch resolution finishes the branch entry. A misprediction clears the valid bit of every younger slot in a single cycle, using a wraparound comparison of snapshot identifiers. A slot that was already issued stays in place until its late result arrives, and that result is then refused. The head port retires one entry per cycle. It reports either a commit, carrying the replaced tag, or a discard, carrying the newly allocated tag, so that the caller can return the right register to its free list.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `ins_ready` is 1 and `ret_valid`, `alu_valid` and `br_valid` are 0.
- R2: An insert is accepted when `ins_valid` and `ins_ready` are both high. `ins_idx` names the slot it takes. Slots are handed out consecutively from 0 and wrap at DEPTH. `ins_ready` is 0 while all DEPTH slots are occupied.
- R3: `alu_idx` names the oldest slot, counted from the head, that is valid, not executing, not finished, has the in-order flag clear and has both source present bits set. `alu_valid` is 1 when such a slot exists.
- R4: `br_valid` is high only for the oldest valid, unfinished slot with the in-order flag set, and only when that slot is not executing and its sources are present. Younger in-order slots wait behind it.
- R5: A slot taken with `alu_take` or `br_take` is marked executing and is not offered again.
- R6: A writeback with `wb_link`=0 clears the executing flag of slot `wb_idx`. If the slot is valid, it also sets its finish flag, and `wb_accept` is 1. Any writeback sets the present bit of every matching source tag in valid slots, including a slot inserted in the same cycle.
- R7: A writeback with `wb_link`=1 is always accepted and broadcasts its tag. It never finishes slot `wb_idx`.
- R8: `res_valid` clears the executing flag of slot `res_idx` and, if that slot is valid, sets its finish flag.
- R9: When the head slot is valid and finished, `ret_valid`=1, `ret_commit`=1 and `ret_tag` is the replaced tag given at insert.
- R10: When the head slot is invalid and not executing, `ret_valid`=1, `ret_commit`=0 and `ret_tag` is the destination tag given at insert.
- R11: When `res_mispredict` is high with `res_valid`, every slot, including one inserted in the same cycle, whose identifier minus `res_sid` is positive as a signed SID_W-bit number loses its valid bit. This holds across wraparound, so 0 is younger than 15 for SID_W=4.
- R12: An invalidated slot that is still executing holds the head (`ret_valid`=0) until its writeback arrives. That writeback sees `wb_accept`=0, and the slot is then discarded.
- R13: Insert, dispatch, writeback and retire all take effect when they occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_inorder | input | 1 | New entry must execute in program order |
| ins_dst | input | TAG_W | Newly allocated destination tag |
| ins_prev | input | TAG_W | Tag previously mapped to the destination |
| ins_src0 | input | TAG_W | First source tag |
| ins_src0_rdy | input | 1 | First source already present |
| ins_src1 | input | TAG_W | Second source tag |
| ins_src1_rdy | input | 1 | Second source already present |
| ins_sid | input | SID_W | Branch snapshot identifier of the new entry |
| ins_ready | output | 1 | Buffer can accept an insert |
| ins_idx | output | IDX_W | Slot the insert takes |
| alu_valid | output | 1 | A ready arithmetic entry is offered |
| alu_idx | output | IDX_W | Slot of the offered arithmetic entry |
| alu_take | input | 1 | Execution side takes the arithmetic entry |
| br_valid | output | 1 | The oldest in-order entry is offered |
| br_idx | output | IDX_W | Slot of the offered in-order entry |
| br_take | input | 1 | Branch unit takes the in-order entry |
| wb_valid | input | 1 | Result writeback |
| wb_link | input | 1 | Writeback is a link value (never speculative) |
| wb_idx | input | IDX_W | Slot the result belongs to |
| wb_tag | input | TAG_W | Tag being written |
| wb_accept | output | 1 | The result may be written to the register file |
| res_valid | input | 1 | Branch resolution |
| res_mispredict | input | 1 | Resolved branch was mispredicted |
| res_idx | input | IDX_W | Slot of the resolved branch |
| res_sid | input | SID_W | Snapshot identifier of the resolved branch |
| ret_valid | output | 1 | Head entry can retire |
| ret_commit | output | 1 | 1 commit, 0 discard |
| ret_tag | output | TAG_W | Tag to return to the free list |
| ret_take | input | 1 | Retire the head entry |

## Verification
The hardest overlap is a misprediction landing in the same cycle as a writeback and an insert. The bench provokes it by resolving a branch as mispredicted while an older entry writes back and a new entry with a later snapshot identifier enters. It then expects the older entry to commit next, the new entry to be offered to no picker, and to be discarded in turn. A second overlap, retire together with insert, is judged by the slot index the insert receives and by which entry the head presents in the following cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_DEPTH_DEF = 8;
    localparam int ROB_TAG_W_DEF = 6;
    localparam int ROB_SID_W_DEF = 4;

    // Per-slot status word
    typedef struct packed {
        logic vld;   // entry is on the correct path
        logic exe;   // issued, result outstanding
        logic ino;   // must run in program order
        logic p0;    // first source present
        logic p1;    // second source present
        logic fin;   // result or resolution received
    } rob_stat_t;

    typedef enum logic [1:0] {
        RK_WAIT    = 2'd0,
        RK_COMMIT  = 2'd1,
        RK_DISCARD = 2'd2
    } ret_kind_e;

    function automatic ret_kind_e head_kind(input rob_stat_t s);
        if (s.vld && s.fin)  return RK_COMMIT;
        if (!s.vld && !s.exe) return RK_DISCARD;
        return RK_WAIT;
    endfunction

    function automatic rob_stat_t fresh_entry(input logic ino, input logic p0, input logic p1);
        rob_stat_t s;
        s.vld = 1'b1;
        s.exe = 1'b0;
        s.ino = ino;
        s.p0  = p0;
        s.p1  = p1;
        s.fin = 1'b0;
        return s;
    endfunction

    function automatic logic alu_cand(input rob_stat_t s);
        return s.vld && !s.exe && !s.fin && !s.ino && s.p0 && s.p1;
    endfunction

    function automatic logic order_cand(input rob_stat_t s);
        return s.vld && s.ino && !s.fin;
    endfunction

endpackage

// File: rtl/rob_pick.sv
// Oldest-first pick: scans candidates starting at a rotating start slot.
module rob_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = start;
        for (int i = 0; i < N; i++) begin
            if (!found && cand[IW'(start + IW'(i))]) begin
                found = 1'b1;
                idx   = IW'(start + IW'(i));
            end
        end
    end
endmodule

// File: rtl/rob_age_mask.sv
// Marks every slot whose snapshot identifier is cyclically after the reference.
module rob_age_mask #(
    parameter int N  = 8,
    parameter int SW = 4
) (
    input  logic [N-1:0][SW-1:0] sid,
    input  logic [SW-1:0]        ref_sid,
    output logic [N-1:0]         younger
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [SW-1:0] diff;
        assign diff       = sid[g] - ref_sid;
        assign younger[g] = !diff[SW-1] && (diff != '0);
    end
endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH_DEF,
    parameter int TAG_W = ROB_TAG_W_DEF,
    parameter int SID_W = ROB_SID_W_DEF,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  logic             ins_inorder,
    input  logic [TAG_W-1:0] ins_dst,
    input  logic [TAG_W-1:0] ins_prev,
    input  logic [TAG_W-1:0] ins_src0,
    input  logic             ins_src0_rdy,
    input  logic [TAG_W-1:0] ins_src1,
    input  logic             ins_src1_rdy,
    input  logic [SID_W-1:0] ins_sid,
    output logic             ins_ready,
    output logic [IDX_W-1:0] ins_idx,
    output logic             alu_valid,
    output logic [IDX_W-1:0] alu_idx,
    input  logic             alu_take,
    output logic             br_valid,
    output logic [IDX_W-1:0] br_idx,
    input  logic             br_take,
    input  logic             wb_valid,
    input  logic             wb_link,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [TAG_W-1:0] wb_tag,
    output logic             wb_accept,
    input  logic             res_valid,
    input  logic             res_mispredict,
    input  logic [IDX_W-1:0] res_idx,
    input  logic [SID_W-1:0] res_sid,
    output logic             ret_valid,
    output logic             ret_commit,
    output logic [TAG_W-1:0] ret_tag,
    input  logic             ret_take
);
    // ---------------- storage ----------------
    rob_stat_t              st_q   [DEPTH];
    rob_stat_t              st_d   [DEPTH];
    logic [TAG_W-1:0]       dst_q  [DEPTH];
    logic [TAG_W-1:0]       prev_q [DEPTH];
    logic [TAG_W-1:0]       s0_q   [DEPTH];
    logic [TAG_W-1:0]       s1_q   [DEPTH];
    logic [DEPTH-1:0][SID_W-1:0] sid_q;
    logic [DEPTH-1:0][SID_W-1:0] sid_view;

    logic [IDX_W-1:0] head_q, tail_q, head_inc, tail_inc;
    logic             full_q, empty_q;

    logic             do_ins, do_ret, do_alu, do_br, squash;
    logic [DEPTH-1:0] alu_cv, br_cv, young;
    logic             br_found;
    ret_kind_e        kind;

    assign head_inc = head_q + 1'b1;
    assign tail_inc = tail_q + 1'b1;

    // ---------------- edge outputs ----------------
    assign ins_ready = !full_q;
    assign ins_idx   = tail_q;
    assign do_ins    = ins_valid && !full_q;

    assign kind       = head_kind(st_q[head_q]);
    assign ret_valid  = !empty_q && (kind != RK_WAIT);
    assign ret_commit = (kind == RK_COMMIT);
    assign ret_tag    = ret_commit ? prev_q[head_q] : dst_q[head_q];
    assign do_ret     = ret_take && ret_valid;

    assign wb_accept  = wb_valid && (wb_link || st_q[wb_idx].vld);
    assign squash     = res_valid && res_mispredict;

    // ---------------- pickers ----------------
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            alu_cv[i] = alu_cand(st_q[i]);
            br_cv[i]  = order_cand(st_q[i]);
        end
    end

    rob_pick #(.N(DEPTH), .IW(IDX_W)) u_alu_pick (
        .cand  (alu_cv),
        .start (head_q),
        .found (alu_valid),
        .idx   (alu_idx)
    );

    rob_pick #(.N(DEPTH), .IW(IDX_W)) u_ord_pick (
        .cand  (br_cv),
        .start (head_q),
        .found (br_found),
        .idx   (br_idx)
    );

    assign br_valid = br_found && !st_q[br_idx].exe && st_q[br_idx].p0 && st_q[br_idx].p1;
    assign do_alu   = alu_valid && alu_take;
    assign do_br    = br_valid && br_take;

    // ---------------- squash mask ----------------
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            sid_view[i] = (do_ins && tail_q == IDX_W'(i)) ? ins_sid : sid_q[i];
    end

    rob_age_mask #(.N(DEPTH), .SW(SID_W)) u_age (
        .sid     (sid_view),
        .ref_sid (res_sid),
        .younger (young)
    );

    // ---------------- next status ----------------
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rob_stat_t        s;
            logic [TAG_W-1:0] t0, t1;
            logic [IDX_W-1:0] me;
            me = IDX_W'(i);
            s  = st_q[i];
            t0 = s0_q[i];
            t1 = s1_q[i];
            if (do_ret && head_q == me)
                s = '0;
            if (do_ins && tail_q == me) begin
                s  = fresh_entry(ins_inorder, ins_src0_rdy, ins_src1_rdy);
                t0 = ins_src0;
                t1 = ins_src1;
            end
            if ((do_alu && alu_idx == me) || (do_br && br_idx == me))
                s.exe = 1'b1;
            if (wb_valid && !wb_link && wb_idx == me) begin
                s.exe = 1'b0;
                if (st_q[i].vld) s.fin = 1'b1;
            end
            if (res_valid && res_idx == me) begin
                s.exe = 1'b0;
                if (st_q[i].vld) s.fin = 1'b1;
            end
            if (wb_valid && (s.vld || wb_link)) begin
                if (t0 == wb_tag) s.p0 = 1'b1;
                if (t1 == wb_tag) s.p1 = 1'b1;
            end
            if (squash && young[i])
                s.vld = 1'b0;
            st_d[i] = s;
        end
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= st_d[i];
            if (do_ins) begin
                dst_q[tail_q]  <= ins_dst;
                prev_q[tail_q] <= ins_prev;
                s0_q[tail_q]   <= ins_src0;
                s1_q[tail_q]   <= ins_src1;
                sid_q[tail_q]  <= ins_sid;
                tail_q         <= tail_inc;
            end
            if (do_ret)
                head_q <= head_inc;
            if (do_ins && !do_ret) begin
                empty_q <= 1'b0;
                full_q  <= (tail_inc == head_q);
            end else if (do_ret && !do_ins) begin
                full_q  <= 1'b0;
                empty_q <= (head_inc == tail_q);
            end
        end
    end
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic             ret_take,
    input logic             ret_valid,
    input logic             alu_valid,
    input logic             alu_take,
    input logic [IDX_W-1:0] alu_idx,
    input logic             br_valid,
    input logic             br_take,
    input logic [IDX_W-1:0] br_idx
);
    logic [IDX_W:0] cnt_q;
    logic           acc_ins, acc_ret;

    assign acc_ins = ins_valid && ins_ready;
    assign acc_ret = ret_take && ret_valid;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + (IDX_W+1)'(acc_ins) - (IDX_W+1)'(acc_ret);
    end

    AST_READY_TRACKS_FILL: assert property (@(posedge clk) disable iff (rst)
        ins_ready == (cnt_q != (IDX_W+1)'(DEPTH))); // R2

    AST_EMPTY_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |-> (!ret_valid && !alu_valid && !br_valid)); // R1

    AST_PICKS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && br_valid) |-> (alu_idx != br_idx)); // R4

    AST_ALU_NOT_REOFFERED: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && alu_take) |=> !(alu_valid && alu_idx == $past(alu_idx))); // R5

    AST_BR_NOT_REOFFERED: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_take) |=> !(br_valid && br_idx == $past(br_idx))); // R5
endmodule

bind rob_top rob_chk #(.DEPTH(DEPTH)) u_rob_chk (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .ret_take  (ret_take),
    .ret_valid (ret_valid),
    .alu_valid (alu_valid),
    .alu_take  (alu_take),
    .alu_idx   (alu_idx),
    .br_valid  (br_valid),
    .br_take   (br_take),
    .br_idx    (br_idx)
);

// File: tb/test_rob_top.sv
`timescale 1ns/1ps
module test_rob_top;
    localparam int DEPTH = 8;
    localparam int TAG_W = 6;
    localparam int SID_W = 4;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             ins_valid, ins_inorder, ins_src0_rdy, ins_src1_rdy;
    logic [TAG_W-1:0] ins_dst, ins_prev, ins_src0, ins_src1;
    logic [SID_W-1:0] ins_sid;
    logic             ins_ready;
    logic [IDX_W-1:0] ins_idx;
    logic             alu_valid, alu_take, br_valid, br_take;
    logic [IDX_W-1:0] alu_idx, br_idx;
    logic             wb_valid, wb_link, wb_accept;
    logic [IDX_W-1:0] wb_idx;
    logic [TAG_W-1:0] wb_tag;
    logic             res_valid, res_mispredict;
    logic [IDX_W-1:0] res_idx;
    logic [SID_W-1:0] res_sid;
    logic             ret_valid, ret_commit, ret_take;
    logic [TAG_W-1:0] ret_tag;

    rob_top #(.DEPTH(DEPTH), .TAG_W(TAG_W), .SID_W(SID_W)) i_rob_top (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_inorder(ins_inorder), .ins_dst(ins_dst),
        .ins_prev(ins_prev), .ins_src0(ins_src0), .ins_src0_rdy(ins_src0_rdy),
        .ins_src1(ins_src1), .ins_src1_rdy(ins_src1_rdy), .ins_sid(ins_sid),
        .ins_ready(ins_ready), .ins_idx(ins_idx),
        .alu_valid(alu_valid), .alu_idx(alu_idx), .alu_take(alu_take),
        .br_valid(br_valid), .br_idx(br_idx), .br_take(br_take),
        .wb_valid(wb_valid), .wb_link(wb_link), .wb_idx(wb_idx), .wb_tag(wb_tag),
        .wb_accept(wb_accept),
        .res_valid(res_valid), .res_mispredict(res_mispredict), .res_idx(res_idx),
        .res_sid(res_sid),
        .ret_valid(ret_valid), .ret_commit(ret_commit), .ret_tag(ret_tag),
        .ret_take(ret_take)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_inorder = 0; ins_dst = 0; ins_prev = 0;
        ins_src0 = 0; ins_src1 = 0; ins_src0_rdy = 0; ins_src1_rdy = 0; ins_sid = 0;
        alu_take = 0; br_take = 0;
        wb_valid = 0; wb_link = 0; wb_idx = 0; wb_tag = 0;
        res_valid = 0; res_mispredict = 0; res_idx = 0; res_sid = 0;
        ret_take = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic put(input logic ino, input int dst, input int s0, input logic r0,
                       input int s1, input logic r1, input int prev, input int sid);
        ins_valid = 1; ins_inorder = ino; ins_dst = TAG_W'(dst); ins_prev = TAG_W'(prev);
        ins_src0 = TAG_W'(s0); ins_src0_rdy = r0; ins_src1 = TAG_W'(s1); ins_src1_rdy = r1;
        ins_sid = SID_W'(sid);
    endtask

    task automatic wb(input int idx, input int tag, input logic link);
        wb_valid = 1; wb_idx = IDX_W'(idx); wb_tag = TAG_W'(tag); wb_link = link;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check("R1 ins_ready", 32'(ins_ready), 1);
        check("R1 ret_valid", 32'(ret_valid), 0);
        check("R1 alu_valid", 32'(alu_valid), 0);
        check("R1 br_valid", 32'(br_valid), 0);

        // ---- fill all 8 slots, sids 0..7 ----
        for (int i = 0; i < DEPTH; i++) begin
            case (i)
                0: put(0, 20, 1, 1, 2, 1, 32, 0);
                1: put(0, 21, 20, 0, 3, 1, 33, 1);
                2: put(1, 22, 4, 1, 5, 1, 34, 2);
                4: put(1, 24, 4, 1, 5, 1, 36, 4);
                default: put(0, 20 + i, 6, 1, 7, 1, 32 + i, i);
            endcase
            #1;
            check("R2 ins_idx", 32'(ins_idx), i);
            step();
        end
        check("R2 full", 32'(ins_ready), 0);
        check("R3 oldest alu", 32'(alu_idx), 0);
        check("R4 oldest in-order", 32'(br_idx), 2);
        check("R4 br_valid", 32'(br_valid), 1);

        alu_take = 1; #1; step();
        check("R3 skip unready and in-order", 32'(alu_idx), 3);

        br_take = 1; alu_take = 1; #1; step();
        check("R4 younger in-order waits", 32'(br_valid), 0);
        check("R5 dispatched not reoffered", 32'(alu_idx), 5);

        wb(0, 20, 0); #1;
        check("R6 accept valid", 32'(wb_accept), 1);
        step();
        check("R6 dependent woken", 32'(alu_idx), 1);
        check("R9 commit valid", 32'(ret_valid), 1);
        check("R9 commit kind", 32'(ret_commit), 1);
        check("R9 commit tag", 32'(ret_tag), 32);

        ret_take = 1; alu_take = 1; #1; step();
        check("R13 retire frees slot", 32'(ins_ready), 1);
        check("R9 head waits unfinished", 32'(ret_valid), 0);

        // misprediction with concurrent writeback and insert (sid 8)
        res_valid = 1; res_mispredict = 1; res_idx = 2; res_sid = 2;
        wb(1, 21, 0);
        put(0, 28, 6, 1, 7, 1, 31, 8);
        #1;
        check("R13 insert during squash idx", 32'(ins_idx), 0);
        check("R6 accept older", 32'(wb_accept), 1);
        step();
        check("R11 no alu after squash", 32'(alu_valid), 0);
        check("R11 in-order squashed", 32'(br_valid), 0);
        check("R13 older commits", 32'(ret_commit), 1);
        check("R13 older tag", 32'(ret_tag), 33);

        ret_take = 1; #1; step();
        check("R8 resolved branch commits", 32'(ret_commit), 1);
        check("R8 branch tag", 32'(ret_tag), 34);

        ret_take = 1; #1; step();
        check("R12 head held by drain", 32'(ret_valid), 0);
        wb(3, 23, 0); #1;
        check("R12 late result refused", 32'(wb_accept), 0);
        step();
        check("R12 drained discards", 32'(ret_valid), 1);
        check("R12 discard kind", 32'(ret_commit), 0);
        check("R10 discard tag", 32'(ret_tag), 23);

        for (int k = 0; k < 5; k++) begin
            ret_take = 1; #1; step();
            check("R10 squashed discard", 32'(ret_commit), 0);
            check("R10 discard tag seq", 32'(ret_tag), (k < 4) ? 24 + k : 28);
        end
        ret_take = 1; #1; step();
        check("R2 empty after drain", 32'(ret_valid), 0);

        // ---- wraparound snapshot ids: 14, 15(in-order), 0, 1 at slots 1..4 ----
        put(0, 40, 6, 1, 7, 1, 41, 14); #1;
        check("R2 wrap slot", 32'(ins_idx), 1);
        step();
        put(1, 42, 6, 1, 7, 1, 43, 15); #1; step();
        put(0, 44, 6, 1, 7, 1, 45, 0);  #1; step();
        put(0, 46, 6, 1, 7, 1, 47, 1);  #1; step();

        wb(1, 50, 1); #1;
        check("R7 link accepted", 32'(wb_accept), 1);
        step();
        check("R7 link does not finish", 32'(ret_valid), 0);
        check("R4 branch offered", 32'(br_idx), 2);

        res_valid = 1; res_mispredict = 1; res_idx = 2; res_sid = 15; #1; step();
        check("R11 older survives", 32'(alu_idx), 1);
        alu_take = 1; #1; step();
        check("R11 wrapped ids squashed", 32'(alu_valid), 0);

        wb(1, 40, 0); #1; step();
        check("R9 commit tag wrap", 32'(ret_tag), 41);

        ret_take = 1; put(0, 48, 6, 1, 7, 1, 49, 2); #1;
        check("R13 insert with retire idx", 32'(ins_idx), 5);
        step();
        check("R13 new entry offered", 32'(alu_idx), 5);
        check("R8 branch head commits", 32'(ret_commit), 1);
        check("R8 branch head tag", 32'(ret_tag), 43);

        ret_take = 1; #1; step();
        check("R10 wrapped discard", 32'(ret_commit), 0);
        check("R10 wrapped discard tag", 32'(ret_tag), 44);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule